// File: doc/BRIEF.md
# NAND Flash Bus Front-End

This block is the device-side bus front-end of an 8/16-bit NAND flash. It watches the asynchronous control pins (write strobe, read strobe, chip select, command and address qualifiers, write guard) through two-flop synchronizers clocked by a faster system clock. Each completed write strobe becomes exactly one bus cycle. The two qualifier pins decide where that cycle goes: the command register, the address shift register, or the page buffer at the current column.

Read strobes return words from a small behavioural page buffer and advance a column pointer that wraps at the page size. The block also does three other jobs. It rejects program and erase opcodes while the write guard is low. It ignores every write cycle until a power-up recovery count has run out. It pulses an abort flag when chip select is released during a multi-page sequential read while the array reports busy.

Top module: `nand_cmd_front`

## Requirements
- R1: A write-strobe rising edge with `cle` high and `ale` low stores `io_in[7:0]` in `cmd_q` and pulses `cmd_stb` for one cycle. `io_in[15:8]` is ignored.
- R2: A write-strobe rising edge with `ale` high and `cle` low shifts `addr_q` left by 8 bits and puts `io_in[7:0]` into bits 7:0. `io_in[15:8]` is ignored. Every accepted command clears `addr_q` to zero.
- R3: A write-strobe rising edge with both qualifiers low writes a word into the page buffer at the current column, then advances the column by one. With `x16` high the word is the full `io_in`. With `x16` low it is `{8'h00, io_in[7:0]}`.
- R4: A write-strobe edge with both `cle` and `ale` high changes no register and no column. It sets `latch_err`, which stays high until reset.
- R5: Each falling edge of the read strobe loads `io_out` with the word at the current column and advances the column by one. After column PAGE_WORDS-1 the column returns to 0.
- R6: The first address byte after an accepted command sets the column to that byte modulo PAGE_WORDS.
- R7: While `wp_n` is low, the opcodes 8'h80, 8'h10, 8'h60 and 8'hD0 are not latched. `cmd_q` keeps its value, no strobe is given, and `wp_reject` goes high. The next accepted command clears `wp_reject`. Other opcodes are accepted as usual.
- R8: `ready` stays low for RECOVERY_CYC cycles after reset and then stays high. Write strobes that complete while `ready` is low have no effect.
- R9: `io_oe` is high only while both chip select and read strobe are (synchronized) low. Otherwise the bus is released.
- R10: `abort_o` pulses for one cycle when chip select rises while `busy_i` and `seq_read_i` are both high. A chip-select rise at any other time gives no pulse.
- R11: After reset `cmd_q`, `addr_q`, the column, `latch_err`, `wp_reject`, `ready` and `io_oe` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the pins |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Command qualifier for write strobes |
| ale | input | 1 | Address qualifier for write strobes |
| we_n | input | 1 | Write strobe; a cycle is taken on its rising edge |
| re_n | input | 1 | Read strobe; a word is fetched on its falling edge |
| wp_n | input | 1 | Write guard; low blocks program and erase opcodes |
| x16 | input | 1 | High selects the 16-bit data bus |
| busy_i | input | 1 | Array busy indication |
| seq_read_i | input | 1 | Array is inside a multi-page sequential read |
| io_in | input | 16 | Incoming bus value |
| io_out | output | 16 | Read data word |
| io_oe | output | 1 | Output enable for the bus drivers |
| cmd_q | output | 8 | Last accepted command opcode |
| cmd_stb | output | 1 | One-cycle pulse per accepted command |
| addr_q | output | 8*ADDR_BYTES | Address shift register |
| col_o | output | COL_W | Current column pointer |
| latch_err | output | 1 | Sticky flag for a cycle with both qualifiers high |
| wp_reject | output | 1 | A guarded opcode was refused |
| ready | output | 1 | Power-up recovery has elapsed |
| abort_o | output | 1 | One-cycle pulse on a busy-time sequential-read abort |

## Verification
The checker asserts the following on every cycle: a command strobe always follows a cycle in which the command qualifier was high; a guarded opcode is only ever accepted while the write guard was high; no command appears before `ready`; `ready` and `latch_err` never fall once set; the bus stays released after chip select has been high for several samples; an abort pulse always has busy and sequential-read behind it. The bench scenarios show what the assertions cannot. Those are the exact contents of the address shifter and the column after each cycle, the data written and then read back in 8-bit and 16-bit mode, column wrap, the rejected-then-accepted opcode sequence, and the absence of an abort pulse when only one of the two busy conditions holds.

// File: rtl/nand_fe_pkg.sv
`timescale 1ns/1ps
package nand_fe_pkg;

    typedef enum logic [1:0] {
        LK_IDLE,
        LK_CMD,
        LK_ADDR,
        LK_DATA
    } latch_kind_e;

    typedef struct packed {
        latch_kind_e kind;
        logic        clash;
        logic [15:0] bus;
    } bus_cycle_t;

    localparam logic [7:0] OP_PROG_SETUP  = 8'h80;
    localparam logic [7:0] OP_PROG_GO     = 8'h10;
    localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
    localparam logic [7:0] OP_ERASE_GO    = 8'hD0;

    // Opcodes that alter the array and therefore obey the write guard.
    function automatic logic is_guarded(input logic [7:0] op);
        return (op == OP_PROG_SETUP) || (op == OP_PROG_GO) ||
               (op == OP_ERASE_SETUP) || (op == OP_ERASE_GO);
    endfunction

    function automatic bus_cycle_t classify(input logic cle, input logic ale,
                                            input logic [15:0] bus);
        bus_cycle_t c;
        c.bus   = bus;
        c.clash = cle & ale;
        unique case ({cle, ale})
            2'b10:   c.kind = LK_CMD;
            2'b01:   c.kind = LK_ADDR;
            2'b00:   c.kind = LK_DATA;
            default: c.kind = LK_IDLE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/nand_fe_sync.sv
`timescale 1ns/1ps
module nand_fe_sync #(
    parameter int             N         = 3,
    parameter int             STAGES    = 2,
    parameter logic [N-1:0]   RESET_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // STAGES synchronizer flops plus one history flop for edge detect
        logic [STAGES:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= {(STAGES+1){RESET_VAL[i]}};
            else     sh <= {sh[STAGES-1:0], async_i[i]};
        end
        assign level_o[i] = sh[STAGES-1];
        assign rise_o[i]  = sh[STAGES-1] & ~sh[STAGES];
        assign fall_o[i]  = ~sh[STAGES-1] & sh[STAGES];
    end
endmodule

// File: rtl/nand_fe_router.sv
`timescale 1ns/1ps
module nand_fe_router
    import nand_fe_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    localparam int ADDR_W    = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              we_rise,
    input  logic              cle,
    input  logic              ale,
    input  logic              wp_n,
    input  logic              x16,
    input  logic [15:0]       io_in,
    output logic [7:0]        cmd_q,
    output logic              cmd_stb,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wr_stb,
    output logic [15:0]       wr_word,
    output logic              col_load,
    output logic [7:0]        col_val,
    output logic              latch_err,
    output logic              wp_reject
);
    bus_cycle_t cyc;
    logic       addr_first;

    assign cyc = classify(cle, ale, io_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q      <= '0;
            cmd_stb    <= 1'b0;
            addr_q     <= '0;
            wr_stb     <= 1'b0;
            wr_word    <= '0;
            col_load   <= 1'b0;
            col_val    <= '0;
            latch_err  <= 1'b0;
            wp_reject  <= 1'b0;
            addr_first <= 1'b0;
        end else begin
            cmd_stb  <= 1'b0;
            wr_stb   <= 1'b0;
            col_load <= 1'b0;
            if (accept && we_rise) begin
                if (cyc.clash) begin
                    latch_err <= 1'b1;
                end else begin
                    unique case (cyc.kind)
                        LK_CMD: begin
                            if (!wp_n && is_guarded(cyc.bus[7:0])) begin
                                wp_reject <= 1'b1;
                            end else begin
                                cmd_q      <= cyc.bus[7:0];
                                cmd_stb    <= 1'b1;
                                wp_reject  <= 1'b0;
                                addr_q     <= '0;
                                addr_first <= 1'b1;
                            end
                        end
                        LK_ADDR: begin
                            addr_q     <= {addr_q[ADDR_W-9:0], cyc.bus[7:0]};
                            addr_first <= 1'b0;
                            if (addr_first) begin
                                col_load <= 1'b1;
                                col_val  <= cyc.bus[7:0];
                            end
                        end
                        LK_DATA: begin
                            wr_stb  <= 1'b1;
                            wr_word <= x16 ? cyc.bus : {8'h00, cyc.bus[7:0]};
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/nand_fe_colbuf.sv
`timescale 1ns/1ps
module nand_fe_colbuf #(
    parameter int  PAGE_WORDS = 16,
    localparam int COL_W      = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             col_load,
    input  logic [7:0]       col_val,
    input  logic             wr_stb,
    input  logic [15:0]      wr_word,
    input  logic             re_fall,
    output logic [COL_W-1:0] col_o,
    output logic [15:0]      rd_word
);
    logic [15:0]      mem [PAGE_WORDS];
    logic [COL_W-1:0] col_next;

    assign col_next = (col_o == COL_W'(PAGE_WORDS - 1)) ? '0 : col_o + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_o   <= '0;
            rd_word <= '0;
        end else if (col_load) begin
            col_o <= COL_W'(int'(col_val) % PAGE_WORDS);
        end else if (wr_stb) begin
            col_o <= col_next;
        end else if (re_fall) begin
            rd_word <= mem[col_o];
            col_o   <= col_next;
        end
    end

    // Behavioural page storage; no reset on purpose.
    always_ff @(posedge clk) begin
        if (!rst && !col_load && wr_stb) mem[col_o] <= wr_word;
    end
endmodule

// File: rtl/nand_cmd_front.sv
`timescale 1ns/1ps
module nand_cmd_front
    import nand_fe_pkg::*;
#(
    parameter int  PAGE_WORDS   = 16,
    parameter int  ADDR_BYTES   = 4,
    parameter int  RECOVERY_CYC = 200,
    parameter int  SYNC_STAGES  = 2,
    localparam int ADDR_W       = 8 * ADDR_BYTES,
    localparam int COL_W        = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1,
    localparam int RC_W         = $clog2(RECOVERY_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              cle,
    input  logic              ale,
    input  logic              we_n,
    input  logic              re_n,
    input  logic              wp_n,
    input  logic              x16,
    input  logic              busy_i,
    input  logic              seq_read_i,
    input  logic [15:0]       io_in,
    output logic [15:0]       io_out,
    output logic              io_oe,
    output logic [7:0]        cmd_q,
    output logic              cmd_stb,
    output logic [ADDR_W-1:0] addr_q,
    output logic [COL_W-1:0]  col_o,
    output logic              latch_err,
    output logic              wp_reject,
    output logic              ready,
    output logic              abort_o
);
    // pin order inside the synchronizer: 0 write strobe, 1 read strobe, 2 chip select
    logic [2:0] pin_lvl, pin_rise, pin_fall;
    logic [RC_W-1:0] rc_cnt;
    logic            wr_stb, col_load;
    logic [15:0]     wr_word;
    logic [7:0]      col_val;

    nand_fe_sync #(.N(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b111)) u_sync (
        .clk(clk), .rst(rst),
        .async_i({ce_n, re_n, we_n}),
        .level_o(pin_lvl), .rise_o(pin_rise), .fall_o(pin_fall)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rc_cnt <= '0;
            ready  <= 1'b0;
        end else if (rc_cnt == RC_W'(RECOVERY_CYC)) begin
            ready  <= 1'b1;
        end else begin
            rc_cnt <= rc_cnt + 1'b1;
        end
    end

    nand_fe_router #(.ADDR_BYTES(ADDR_BYTES)) u_router (
        .clk(clk), .rst(rst), .accept(ready), .we_rise(pin_rise[0]),
        .cle(cle), .ale(ale), .wp_n(wp_n), .x16(x16), .io_in(io_in),
        .cmd_q(cmd_q), .cmd_stb(cmd_stb), .addr_q(addr_q),
        .wr_stb(wr_stb), .wr_word(wr_word),
        .col_load(col_load), .col_val(col_val),
        .latch_err(latch_err), .wp_reject(wp_reject)
    );

    nand_fe_colbuf #(.PAGE_WORDS(PAGE_WORDS)) u_colbuf (
        .clk(clk), .rst(rst), .col_load(col_load), .col_val(col_val),
        .wr_stb(wr_stb), .wr_word(wr_word), .re_fall(pin_fall[1]),
        .col_o(col_o), .rd_word(io_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            io_oe   <= 1'b0;
            abort_o <= 1'b0;
        end else begin
            io_oe   <= ~pin_lvl[2] & ~pin_lvl[1];
            abort_o <= pin_rise[2] & busy_i & seq_read_i;
        end
    end
endmodule

// File: rtl/nand_fe_chk.sv
`timescale 1ns/1ps
module nand_fe_chk
    import nand_fe_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ce_n,
    input logic       cle,
    input logic       wp_n,
    input logic       busy_i,
    input logic       seq_read_i,
    input logic [7:0] cmd_q,
    input logic       cmd_stb,
    input logic       latch_err,
    input logic       ready,
    input logic       io_oe,
    input logic       abort_o
);
    a_r1_cmd_needs_cle: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |-> $past(cle));

    a_r4_err_sticky: assert property (@(posedge clk) disable iff (rst)
        latch_err |=> latch_err);

    a_r7_guard_respected: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && is_guarded(cmd_q)) |-> $past(wp_n));

    a_r8_quiet_before_ready: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !cmd_stb);

    a_r8_ready_holds: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    a_r9_released_when_deselected: assert property (@(posedge clk) disable iff (rst)
        ($past(ce_n, 1) && $past(ce_n, 2) && $past(ce_n, 3) && $past(ce_n, 4)) |-> !io_oe);

    a_r10_abort_cause: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> $past(busy_i && seq_read_i));
endmodule

bind nand_cmd_front nand_fe_chk u_chk (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .wp_n(wp_n),
    .busy_i(busy_i), .seq_read_i(seq_read_i), .cmd_q(cmd_q),
    .cmd_stb(cmd_stb), .latch_err(latch_err), .ready(ready),
    .io_oe(io_oe), .abort_o(abort_o)
);

// File: tb/test_nand_cmd_front.sv
`timescale 1ns/1ps
module test_nand_cmd_front;
    localparam int PAGE_WORDS = 16;
    localparam int ADDR_BYTES = 4;
    localparam int COL_W      = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
    logic        wp_n = 1'b1, x16 = 1'b1, busy_i = 1'b0, seq_read_i = 1'b0;
    logic [15:0] io_in = '0;
    logic [15:0] io_out;
    logic        io_oe, cmd_stb, latch_err, wp_reject, ready, abort_o;
    logic [7:0]  cmd_q;
    logic [31:0] addr_q;
    logic [COL_W-1:0] col_o;

    int n_vec = 0, n_bad = 0, n_abort = 0, n_cmd = 0;

    always #2.5 clk = ~clk;

    nand_cmd_front #(.PAGE_WORDS(PAGE_WORDS), .ADDR_BYTES(ADDR_BYTES),
                     .RECOVERY_CYC(200)) i_nand_cmd_front (
        .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .wp_n(wp_n), .x16(x16), .busy_i(busy_i),
        .seq_read_i(seq_read_i), .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
        .cmd_q(cmd_q), .cmd_stb(cmd_stb), .addr_q(addr_q), .col_o(col_o),
        .latch_err(latch_err), .wp_reject(wp_reject), .ready(ready),
        .abort_o(abort_o)
    );

    always @(posedge clk) begin
        if (abort_o) n_abort++;
        if (cmd_stb) n_cmd++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic c, input logic a, input logic [15:0] v);
        wait_cyc(1);
        cle = c; ale = a; io_in = v; we_n = 1'b0;
        wait_cyc(4);
        we_n = 1'b1;
        wait_cyc(6);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic bus_read(output logic [15:0] d, output logic oe);
        wait_cyc(1);
        re_n = 1'b0;
        wait_cyc(6);
        d = io_out; oe = io_oe;
        re_n = 1'b1;
        wait_cyc(6);
    endtask

    // kind: 0 command (expect cmd_q), 1 address (expect addr_q[15:0]),
    //       2 data (expect column afterwards), 3 read (expect io_out)
    localparam int NV = 12;
    localparam logic [33:0] VEC [NV] = '{
        {2'd0, 16'h0080, 16'h0080},
        {2'd1, 16'h0003, 16'h0003},
        {2'd1, 16'h7700, 16'h0300},
        {2'd2, 16'hA1B2, 16'h0004},
        {2'd2, 16'h1234, 16'h0005},
        {2'd2, 16'hFFFF, 16'h0006},
        {2'd0, 16'h0010, 16'h0010},
        {2'd0, 16'h0000, 16'h0000},
        {2'd1, 16'h0003, 16'h0003},
        {2'd3, 16'h0000, 16'hA1B2},
        {2'd3, 16'h0000, 16'h1234},
        {2'd3, 16'h0000, 16'hFFFF}
    };

    initial begin
        logic [15:0] d;
        logic        oe;
        int          ab0;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        // R11 reset state
        chk("R11 cmd_q", {24'h0, cmd_q}, 32'h0);
        chk("R11 addr_q", addr_q, 32'h0);
        chk("R11 col", {28'h0, col_o}, 32'h0);
        chk("R11 flags", {28'h0, latch_err, wp_reject, ready, io_oe}, 32'h0);

        // R8 write cycle before recovery has elapsed is dropped
        bus_write(1'b1, 1'b0, 16'h0055);
        chk("R8 early cmd dropped", {24'h0, cmd_q}, 32'h0);
        chk("R8 no strobe early", n_cmd, 0);
        chk("R8 ready low", {31'h0, ready}, 32'h0);
        wait_cyc(200);
        chk("R8 ready high", {31'h0, ready}, 32'h1);

        // table walk: R1, R2, R3, R5, R6
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  k;
            logic [15:0] v, e;
            {k, v, e} = VEC[i];
            case (k)
                2'd0: begin bus_write(1'b1, 1'b0, v); chk("R1 command", {24'h0, cmd_q}, {16'h0, e}); end
                2'd1: begin bus_write(1'b0, 1'b1, v); chk("R2 R6 address", {16'h0, addr_q[15:0]}, {16'h0, e}); end
                2'd2: begin bus_write(1'b0, 1'b0, v); chk("R3 data column", {28'h0, col_o}, {16'h0, e}); end
                default: begin
                    bus_read(d, oe);
                    chk("R5 read word", {16'h0, d}, {16'h0, e});
                    chk("R9 oe while reading", {31'h0, oe}, 32'h1);
                end
            endcase
        end
        chk("R5 column after reads", {28'h0, col_o}, 32'h6);

        // R1 upper byte ignored on a command cycle
        bus_write(1'b1, 1'b0, 16'hEE00);
        chk("R1 upper byte ignored", {24'h0, cmd_q}, 32'h0);

        // R4 both qualifiers high
        bus_write(1'b1, 1'b1, 16'h0033);
        chk("R4 err set", {31'h0, latch_err}, 32'h1);
        chk("R4 cmd untouched", {24'h0, cmd_q}, 32'h0);
        chk("R4 addr untouched", addr_q, 32'h0);

        // R7 write guard
        wp_n = 1'b0;
        bus_write(1'b1, 1'b0, 16'h0060);
        chk("R7 erase refused", {24'h0, cmd_q}, 32'h0);
        chk("R7 reject flag", {31'h0, wp_reject}, 32'h1);
        bus_write(1'b1, 1'b0, 16'h00D0);
        chk("R7 confirm refused", {24'h0, cmd_q}, 32'h0);
        bus_write(1'b1, 1'b0, 16'h0070);
        chk("R7 other opcode taken", {24'h0, cmd_q}, 32'h70);
        chk("R7 reject cleared", {31'h0, wp_reject}, 32'h0);
        wp_n = 1'b1;

        // R5 R6 wrap: column loaded from address byte modulo page size
        bus_write(1'b1, 1'b0, 16'h0000);
        bus_write(1'b0, 1'b1, 16'h001F);
        chk("R6 column modulo", {28'h0, col_o}, 32'hF);
        bus_read(d, oe);
        chk("R5 column wraps", {28'h0, col_o}, 32'h0);

        // R3 eight-bit data path
        x16 = 1'b0;
        bus_write(1'b1, 1'b0, 16'h0080);
        bus_write(1'b0, 1'b1, 16'h0007);
        bus_write(1'b0, 1'b0, 16'hC3A5);
        bus_write(1'b1, 1'b0, 16'h0000);
        bus_write(1'b0, 1'b1, 16'h0007);
        bus_read(d, oe);
        chk("R3 x8 upper zero", {16'h0, d}, 32'h00A5);
        x16 = 1'b1;

        // R9 released when deselected or not reading
        chk("R9 idle released", {31'h0, io_oe}, 32'h0);
        ce_n = 1'b1; re_n = 1'b0;
        wait_cyc(8);
        chk("R9 deselected released", {31'h0, io_oe}, 32'h0);
        re_n = 1'b1; ce_n = 1'b0;
        wait_cyc(8);

        // R10 abort only with busy and sequential read together
        ab0 = n_abort;
        busy_i = 1'b1; seq_read_i = 1'b1;
        wait_cyc(2); ce_n = 1'b1; wait_cyc(6); ce_n = 1'b0; wait_cyc(6);
        chk("R10 abort pulse", n_abort, ab0 + 1);
        seq_read_i = 1'b0;
        wait_cyc(2); ce_n = 1'b1; wait_cyc(6); ce_n = 1'b0; wait_cyc(6);
        chk("R10 busy only", n_abort, ab0 + 1);
        busy_i = 1'b0; seq_read_i = 1'b1;
        wait_cyc(2); ce_n = 1'b1; wait_cyc(6); ce_n = 1'b0; wait_cyc(6);
        chk("R10 seq only", n_abort, ab0 + 1);
        seq_read_i = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL R8 watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule